// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block folds the four interrupt pins of every device on a PCI bus onto four shared interrupt lines and then steers each shared line onto one of sixteen legacy interrupt-controller inputs. A device reports a level change by presenting its device/function byte, its pin (0 for INTA through 3 for INTD) and the new level for one cycle. The block rotates the pin by the slot number, so that devices in neighbouring slots spread across the shared lines. It stores the level of the selected shared line.

Four byte-wide steering registers, one per shared line, choose the legacy input each line drives. A value of 16 or more disconnects the line. Every legacy output is the OR of all shared lines currently steered to it. The whole output vector is recomputed from the stored levels and the steering registers on every event. A routing change therefore drops the input the line left and raises the one it joined in the same cycle.

Top module: `irq_steer_router`

## Requirements
- R1: After reset every steering register holds 0x80, all stored line levels are 0 and `legacyIrq` is 0. Raising any line before a steering write leaves `legacyIrq` at 0.
- R2: A level event selects shared line (pin + slot - 1) mod 4. The slot is `devFn[7:3]`, the function bits `devFn[2:0]` play no part, and pins 0..3 stand for INTA..INTD.
- R3: A steering value from 0 to 15 connects its line to `legacyIrq` bit number equal to that value, including the boundary value 15.
- R4: A steering value of 16 or more, including 0x10 and 0x80, disconnects the line. The line then drives no output bit.
- R5: Each `legacyIrq` bit is the OR of the stored levels of all lines steered to it. A bit stays high while any of its lines is high.
- R6: Rewriting a steering register clears the line's contribution to the bit it left and adds it to the bit it joined, in the same update.
- R7: `legacyIrq` is registered. It changes on the first rising clock edge after a level event or register write and holds otherwise.
- R8: The steering registers for shared lines 0, 1, 2 and 3 sit at addresses 0x60, 0x61, 0x62 and 0x63 in that order. A write to any other address changes nothing.
- R9: A line's stored level is kept while the line is disconnected. It appears on the output as soon as the line is steered to a valid input.
- R10: Slot 0 wraps under the mod-4 arithmetic, so slot 0 pin 0 selects shared line 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devValid | input | 1 | One-cycle strobe for a device level event |
| devFn | input | 8 | Device/function byte of the reporting device |
| devPin | input | 2 | Interrupt pin of the device, 0 to 3 |
| devLevel | input | 1 | New level of that pin |
| regWrEn | input | 1 | Steering register write strobe |
| regAddr | input | 8 | Register address of the write |
| regWrData | input | 8 | Byte to write |
| legacyIrq | output | 16 | Registered legacy interrupt levels |

## Verification
The bench rotates pins with slot 0, with slots above 3 and with nonzero function bits. A wrong rotation or a missing wrap lights the wrong output bit or none. It moves a line that is still high from one input to another and then to the disconnect values 0x10 and 0x80. A design that only recomputes the new target would leave the old bit stuck high. It also checks that a line kept high while disconnected reappears on the output. With two lines sharing one input, it lowers one of them and expects the bit to stay up. It writes to 0x5F and 0x64 to show that an address decode that is one off gets caught. Finally, it samples one cycle early to confirm the single register stage.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int PIRQ_W  = 2;
  localparam int STEER_W = 8;

  typedef struct packed {
    logic               levelWe;
    logic [PIRQ_W-1:0]  levelIdx;
    logic               levelVal;
    logic               steerWe;
    logic [PIRQ_W-1:0]  steerIdx;
    logic [STEER_W-1:0] steerVal;
  } strobe_t;
endpackage

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
  import irq_steer_pkg::*;
#(
  parameter int          FN_W      = 8,
  parameter int          SLOT_LSB  = 3,
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  BASE_ADDR = 8'h60
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               devValid,
  input  logic [FN_W-1:0]    devFn,
  input  logic [PIRQ_W-1:0]  devPin,
  input  logic               devLevel,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [STEER_W-1:0] regWrData,
  output strobe_t            strb
);
  localparam int SLOT_W = FN_W - SLOT_LSB;

  logic [SLOT_W-1:0] slotNum;
  logic [PIRQ_W-1:0] lineIdx;
  logic              addrHit;

  assign slotNum = devFn[FN_W-1:SLOT_LSB];
  // truncation to PIRQ_W bits performs the mod-4 wrap, slot 0 included
  assign lineIdx = devPin + slotNum[PIRQ_W-1:0] - PIRQ_W'(1);
  assign addrHit = (regAddr[ADDR_W-1:PIRQ_W] == BASE_ADDR[ADDR_W-1:PIRQ_W]);

  always_comb begin
    strb          = '0;
    strb.levelWe  = devValid;
    strb.levelIdx = lineIdx;
    strb.levelVal = devLevel;
    strb.steerWe  = regWrEn && addrHit;
    strb.steerIdx = regAddr[PIRQ_W-1:0];
    strb.steerVal = regWrData;
  end

  // R2: a slot congruent to 1 leaves the pin unrotated
  a_r2_identity: assert property (@(posedge clk) disable iff (!rstN)
    (devValid && devFn[SLOT_LSB+1:SLOT_LSB] == 2'b01) |-> (strb.levelIdx == devPin));

  // R8: writes outside the steering window never reach the registers
  a_r8_decode: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (regAddr < BASE_ADDR || regAddr > BASE_ADDR + 8'd3)) |-> !strb.steerWe);
endmodule

// File: rtl/irq_steer_dp.sv
module irq_steer_dp
  import irq_steer_pkg::*;
#(
  parameter int                 NUM_PIRQ    = 4,
  parameter int                 NUM_IRQ     = 16,
  parameter logic [STEER_W-1:0] STEER_RESET = 8'h80
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  output logic [NUM_IRQ-1:0] irqOut
);
  localparam int IRQ_W = $clog2(NUM_IRQ);

  logic [NUM_PIRQ-1:0] levelQ, levelNext;
  logic [STEER_W-1:0]  steerQ    [NUM_PIRQ];
  logic [STEER_W-1:0]  steerNext [NUM_PIRQ];
  logic [NUM_IRQ-1:0]  lineDecode [NUM_PIRQ];
  logic [NUM_IRQ-1:0]  irqNext, irqQ;

  always_comb begin
    levelNext = levelQ;
    if (strb.levelWe) levelNext[strb.levelIdx] = strb.levelVal;
  end

  for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_line
    always_comb begin
      steerNext[p] = steerQ[p];
      if (strb.steerWe && strb.steerIdx == PIRQ_W'(p)) steerNext[p] = strb.steerVal;
      lineDecode[p] = '0;
      if (levelNext[p] && steerNext[p] < STEER_W'(NUM_IRQ))
        lineDecode[p][steerNext[p][IRQ_W-1:0]] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) steerQ[p] <= STEER_RESET;
      else       steerQ[p] <= steerNext[p];
    end
  end

  always_comb begin
    irqNext = '0;
    for (int p = 0; p < NUM_PIRQ; p++) irqNext = irqNext | lineDecode[p];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ <= '0;
      irqQ   <= '0;
    end else begin
      levelQ <= levelNext;
      irqQ   <= irqNext;
    end
  end

  assign irqOut = irqQ;

  logic             hitOk;
  logic [IRQ_W-1:0] hitIrq;
  assign hitIrq = steerQ[strb.levelIdx][IRQ_W-1:0];
  assign hitOk  = strb.levelWe && strb.levelVal && !strb.steerWe &&
                  (steerQ[strb.levelIdx] < STEER_W'(NUM_IRQ));

  // R7: with no event the output holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.levelWe && !strb.steerWe) |=> $stable(irqQ));

  // R5: raising a routed line forces its input high on the next cycle
  a_r5_raise: assert property (@(posedge clk) disable iff (!rstN)
    hitOk |=> irqQ[$past(hitIrq)]);

  // R4: four lines can light at most four inputs
  a_r4_bound: assert property (@(posedge clk) disable iff (!rstN)
    $countones(irqQ) <= NUM_PIRQ);
endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router
  import irq_steer_pkg::*;
#(
  parameter int NUM_IRQ = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               devValid,
  input  logic [7:0]         devFn,
  input  logic [1:0]         devPin,
  input  logic               devLevel,
  input  logic               regWrEn,
  input  logic [7:0]         regAddr,
  input  logic [7:0]         regWrData,
  output logic [NUM_IRQ-1:0] legacyIrq
);
  strobe_t strb;

  irq_steer_ctrl #(
    .FN_W(8), .SLOT_LSB(3), .ADDR_W(8), .BASE_ADDR(8'h60)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .devValid(devValid), .devFn(devFn), .devPin(devPin), .devLevel(devLevel),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .strb(strb)
  );

  irq_steer_dp #(
    .NUM_PIRQ(4), .NUM_IRQ(NUM_IRQ), .STEER_RESET(8'h80)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .irqOut(legacyIrq)
  );
endmodule

// File: tb/irq_steer_router_test.sv
module irq_steer_router_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        devValid = 1'b0;
  logic [7:0]  devFn = '0;
  logic [1:0]  devPin = '0;
  logic        devLevel = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [15:0] legacyIrq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_steer_router uut (
    .clk(clk), .rstN(rstN), .devValid(devValid), .devFn(devFn), .devPin(devPin),
    .devLevel(devLevel), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .legacyIrq(legacyIrq)
  );

  // {req[3:0], op[1:0], fn[7:0], pin[1:0], lvl, addr[7:0], data[7:0], exp[15:0]}
  // op 1 = level event, op 2 = register write
  localparam int NV = 24;
  localparam logic [48:0] VEC [NV] = '{
    {4'd3,  2'd2, 8'h00, 2'd0, 1'b0, 8'h60, 8'h05, 16'h0000}, // R3 line0 -> irq5, level low
    {4'd2,  2'd1, 8'h08, 2'd0, 1'b1, 8'h00, 8'h00, 16'h0020}, // R2 slot1 pin0 -> line0
    {4'd3,  2'd2, 8'h00, 2'd0, 1'b0, 8'h61, 8'h05, 16'h0020}, // R3 line1 -> irq5
    {4'd5,  2'd1, 8'h08, 2'd1, 1'b1, 8'h00, 8'h00, 16'h0020}, // R5 two lines on irq5
    {4'd5,  2'd1, 8'h08, 2'd0, 1'b0, 8'h00, 8'h00, 16'h0020}, // R5 one drops, OR holds
    {4'd5,  2'd1, 8'h08, 2'd1, 1'b0, 8'h00, 8'h00, 16'h0000}, // R5 both low
    {4'd2,  2'd1, 8'h10, 2'd0, 1'b1, 8'h00, 8'h00, 16'h0020}, // R2 slot2 pin0 -> line1
    {4'd6,  2'd2, 8'h00, 2'd0, 1'b0, 8'h61, 8'h0B, 16'h0800}, // R6 move irq5 -> irq11
    {4'd4,  2'd2, 8'h00, 2'd0, 1'b0, 8'h61, 8'h80, 16'h0000}, // R4 disconnect 0x80
    {4'd4,  2'd2, 8'h00, 2'd0, 1'b0, 8'h61, 8'h10, 16'h0000}, // R4 boundary 16
    {4'd9,  2'd2, 8'h00, 2'd0, 1'b0, 8'h61, 8'h0F, 16'h8000}, // R9 kept level reappears, R3 15
    {4'd8,  2'd2, 8'h00, 2'd0, 1'b0, 8'h64, 8'h00, 16'h8000}, // R8 above window ignored
    {4'd8,  2'd2, 8'h00, 2'd0, 1'b0, 8'h5F, 8'h00, 16'h8000}, // R8 below window ignored
    {4'd10, 2'd1, 8'h00, 2'd0, 1'b1, 8'h00, 8'h00, 16'h8000}, // R10 slot0 pin0 -> line3 (off)
    {4'd10, 2'd2, 8'h00, 2'd0, 1'b0, 8'h63, 8'h00, 16'h8001}, // R10 line3 -> irq0 shows it
    {4'd10, 2'd1, 8'h00, 2'd1, 1'b1, 8'h00, 8'h00, 16'h8021}, // R10 slot0 pin1 -> line0
    {4'd2,  2'd1, 8'h18, 2'd3, 1'b0, 8'h00, 8'h00, 16'h0021}, // R2 slot3 pin3 -> line1
    {4'd3,  2'd2, 8'h00, 2'd0, 1'b0, 8'h62, 8'h00, 16'h0021}, // R3 line2 -> irq0
    {4'd2,  2'd1, 8'h20, 2'd3, 1'b1, 8'h00, 8'h00, 16'h0021}, // R2 slot4 pin3 -> line2
    {4'd5,  2'd1, 8'h00, 2'd0, 1'b0, 8'h00, 8'h00, 16'h0021}, // R5 line3 low, line2 keeps irq0
    {4'd5,  2'd1, 8'h20, 2'd3, 1'b0, 8'h00, 8'h00, 16'h0020}, // R5 irq0 drops
    {4'd2,  2'd1, 8'h0D, 2'd2, 1'b1, 8'h00, 8'h00, 16'h0021}, // R2 slot1 fn5 pin2 -> line2
    {4'd6,  2'd2, 8'h00, 2'd0, 1'b0, 8'h62, 8'h05, 16'h0020}, // R6 line2 joins irq5
    {4'd6,  2'd2, 8'h00, 2'd0, 1'b0, 8'h60, 8'h80, 16'h0020}  // R6 line0 leaves, line2 holds
  };

  task automatic check(input int req, input logic [15:0] exp, input string what);
    total++;
    if (legacyIrq !== exp) begin
      bad++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, legacyIrq, exp);
    end
  endtask

  task automatic levelEvt(input logic [7:0] fn, input logic [1:0] pin, input logic lvl);
    @(negedge clk);
    devValid = 1'b1; devFn = fn; devPin = pin; devLevel = lvl;
    @(negedge clk);
    devValid = 1'b0;
  endtask

  task automatic regWrite(input logic [7:0] addr, input logic [7:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(1, 16'h0000, "output after reset");

    // R1: all lines high with reset steering keeps outputs low
    for (int p = 0; p < 4; p++) levelEvt(8'h08, 2'(p), 1'b1);
    check(1, 16'h0000, "lines high, steering at reset value");
    for (int p = 0; p < 4; p++) levelEvt(8'h08, 2'(p), 1'b0);
    check(1, 16'h0000, "lines lowered");

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  req;
      logic [1:0]  op, pin;
      logic [7:0]  fn, addr, data;
      logic        lvl;
      logic [15:0] exp;
      {req, op, fn, pin, lvl, addr, data, exp} = VEC[i];
      if (op == 2'd1) levelEvt(fn, pin, lvl);
      else            regWrite(addr, data);
      check(int'(req), exp, $sformatf("vector %0d", i));
    end

    // R7: output holds before the edge and changes right after it
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 8'h63; regWrData = 8'h07;
    #2;
    check(7, 16'h0020, "before edge");
    @(posedge clk); #1;
    regWrEn = 1'b0;
    check(7, 16'h0020, "line3 low, no change");
    levelEvt(8'h00, 2'd0, 1'b1);
    check(7, 16'h00A0, "one edge after level event");
    repeat (3) @(negedge clk);
    check(7, 16'h00A0, "holds with no event");

    // R1: reset restores disconnected steering and clears levels
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check(1, 16'h0000, "after second reset");
    levelEvt(8'h10, 2'd1, 1'b1);
    check(1, 16'h0000, "steering reverted to disconnected");
    regWrite(8'h62, 8'h03);
    check(1, 16'h0008, "line2 routed after reset");
    regWrite(8'h61, 8'h03);
    check(1, 16'h0008, "line1 level cleared by reset");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule